// File: doc/BRIEF.md
# ATA Channel Configuration and I/O Address Decoder

This block holds the configuration registers and the I/O address decode for a two-channel ATA host controller. Each channel runs either in legacy compatibility mode, where it claims fixed I/O addresses, or in native mode, where two programmable base registers place its command block and its control register. The mode bit of a channel also decides whether software can see that channel's base registers. Together, the two mode bits decide whether the interrupt line and pin fields are live.

A config port with a dword index, byte enables and write data updates the registers, and the read data is a combinational function of the index. On the I/O side, each valid request yields at most one of four hit strobes in the same cycle. Each channel's interrupt request goes to its own legacy line in compatibility mode. In native mode it goes to the shared level interrupt A.

Top module: `ide_chan_decode`

## Requirements
- R1: After reset, both channels are in compatibility mode. Dword 2 (byte offset 08h) reads 0101_0200h, dwords 4..7 read 0, dword 15 (3Ch) reads 0 and dword 3 (0Ch) reads 0.
- R2: Byte 1 of dword 2 is the mode byte, written only when cfg_be[1] is set. Write-data bit 8 sets primary native mode and bit 10 sets secondary native mode. Read bit 9 is always 1 and read bits 15:11 are always 0.
- R3: In compatibility mode, the primary command strobe covers I/O 1F0h..1F7h and the primary control strobe covers only 3F6h. The secondary strobes cover 170h..177h and 376h.
- R4: In native mode, a channel's command base (primary dword 4, secondary dword 6) keeps write bits 31:3 and reads 001b in bits 2:0. The command base decodes an 8-byte window. Its control base (dword 5 or 7) keeps bits 31:2 and reads 01b in bits 1:0, and only window byte 2 hits. The legacy addresses of that channel are then not claimed. In compatibility mode these dwords read 0 and writes to them are dropped.
- R5: A mode change reaches the decode in the cycle after the write edge. A request in the writing cycle still sees the old mode.
- R6: Config writes change only the bytes whose cfg_be bit is set. Writes to read-only bits leave them unchanged.
- R7: When either channel is native, byte 0 of dword 15 is the read-write interrupt line and byte 1 reads 01h. When neither channel is native, the whole dword reads 0 and writes are dropped, and the stored line value returns once a channel is native again.
- R8: In dword 3, the cache-line byte 0, header byte 2 and self-test byte 3 read 0 and ignore writes. The latency byte 1 reads back what was written and does not change the decode.
- R9: No hit is asserted while io_valid_i is low, nor for a channel whose chan_en_i bit (0 primary, 1 secondary) is low.
- R10: At most one hit is asserted per request. When windows overlap, the order is primary command, primary control, secondary command, secondary control.
- R11: chan_irq_i[n] drives leg_irq_o[n] when channel n is in compatibility mode. It drives inta_o (OR of the native channels) when the channel is in native mode, and never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Config write strobe |
| cfg_addr_i | input | 6 | Config dword index |
| cfg_be_i | input | 4 | Config byte enables |
| cfg_wdata_i | input | 32 | Config write data |
| cfg_rdata_o | output | 32 | Config read data for cfg_addr_i |
| io_valid_i | input | 1 | I/O request valid |
| io_addr_i | input | 16 | I/O request address |
| chan_en_i | input | 2 | Channel enables, bit 0 primary |
| pri_cmd_hit_o | output | 1 | Primary command block hit |
| pri_ctl_hit_o | output | 1 | Primary control register hit |
| sec_cmd_hit_o | output | 1 | Secondary command block hit |
| sec_ctl_hit_o | output | 1 | Secondary control register hit |
| chan_irq_i | input | 2 | Channel interrupt requests |
| leg_irq_o | output | 2 | Legacy interrupt lines, bit 0 primary |
| inta_o | output | 1 | Shared interrupt A |

## Verification
A wrong mode bit or base register has no outputs of its own, so it shows only in the hit pattern and the routed interrupts. The decode and read paths are combinational, so the fault appears in the same cycle as the first request to an affected address. Full sweeps of the low 1 KiB of I/O space under several mode, base and enable settings therefore expose a misplaced window, a missed byte, or a wrong priority in the first cycle it applies. The interrupt outputs and the readback of each base and mode byte show state faults directly.

// File: rtl/ide_dec_pkg.sv
`timescale 1ns/1ps
package ide_dec_pkg;
  localparam int NCH = 2;
  localparam int CFG_IW = 6;

  localparam logic [CFG_IW-1:0] OFS_CLASS = 6'h02;
  localparam logic [CFG_IW-1:0] OFS_MISC  = 6'h03;
  localparam logic [CFG_IW-1:0] OFS_BAR0  = 6'h04;
  localparam logic [CFG_IW-1:0] OFS_INTR  = 6'h0F;

  localparam logic [31:0] CMD_WMASK = 32'hFFFF_FFF8;
  localparam logic [31:0] CTL_WMASK = 32'hFFFF_FFFC;

  typedef struct packed {
    logic        native;
    logic [28:0] cmd_hi;
    logic [29:0] ctl_hi;
  } chan_cfg_t;

  function automatic logic [31:0] leg_cmd(input int ch);
    return (ch == 0) ? 32'h0000_01F0 : 32'h0000_0170;
  endfunction

  function automatic logic [31:0] leg_ctl(input int ch);
    return (ch == 0) ? 32'h0000_03F4 : 32'h0000_0374;
  endfunction

  function automatic logic [31:0] be_merge(input logic [31:0] cur, input logic [31:0] wr,
                                           input logic [3:0] be, input logic [31:0] wmask);
    logic [31:0] res;
    res = cur;
    for (int b = 0; b < 4; b++) begin
      if (be[b]) begin
        res[8*b +: 8] = (cur[8*b +: 8] & ~wmask[8*b +: 8]) | (wr[8*b +: 8] & wmask[8*b +: 8]);
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/ide_cfg_regs.sv
`timescale 1ns/1ps
module ide_cfg_regs
  import ide_dec_pkg::*;
#(
  parameter logic [7:0]  REV_ID     = 8'h00,
  parameter logic [15:0] CLASS_CODE = 16'h0101
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_wr_i,
  input  logic [CFG_IW-1:0]       cfg_addr_i,
  input  logic [3:0]              cfg_be_i,
  input  logic [31:0]             cfg_wdata_i,
  output logic [31:0]             cfg_rdata_o,
  output chan_cfg_t [NCH-1:0]     chan_o
);
  logic [NCH-1:0]        native_q, native_d;
  logic [NCH-1:0][31:0]  cmd_q, cmd_d;
  logic [NCH-1:0][31:0]  ctl_q, ctl_d;
  logic [7:0]            lat_q, lat_d;
  logic [7:0]            line_q, line_d;
  logic                  any_native;

  assign any_native = |native_q;

  // next state
  always_comb begin
    native_d = native_q;
    cmd_d    = cmd_q;
    ctl_d    = ctl_q;
    lat_d    = lat_q;
    line_d   = line_q;
    if (cfg_wr_i) begin
      if (cfg_addr_i == OFS_CLASS && cfg_be_i[1]) begin
        native_d[0] = cfg_wdata_i[8];
        native_d[1] = cfg_wdata_i[10];
      end
      if (cfg_addr_i == OFS_MISC && cfg_be_i[1]) lat_d = cfg_wdata_i[15:8];
      if (cfg_addr_i == OFS_INTR && cfg_be_i[0] && any_native) line_d = cfg_wdata_i[7:0];
      for (int ch = 0; ch < NCH; ch++) begin
        if (native_q[ch] && cfg_addr_i == OFS_BAR0 + CFG_IW'(2*ch))
          cmd_d[ch] = be_merge(cmd_q[ch], cfg_wdata_i, cfg_be_i, CMD_WMASK);
        if (native_q[ch] && cfg_addr_i == OFS_BAR0 + CFG_IW'(2*ch + 1))
          ctl_d[ch] = be_merge(ctl_q[ch], cfg_wdata_i, cfg_be_i, CTL_WMASK);
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      native_q <= '0;
      lat_q    <= '0;
      line_q   <= '0;
      for (int ch = 0; ch < NCH; ch++) begin
        cmd_q[ch] <= leg_cmd(ch) | 32'h1;
        ctl_q[ch] <= leg_ctl(ch) | 32'h1;
      end
    end else begin
      native_q <= native_d;
      lat_q    <= lat_d;
      line_q   <= line_d;
      cmd_q    <= cmd_d;
      ctl_q    <= ctl_d;
    end
  end

  // readback
  always_comb begin
    cfg_rdata_o = '0;
    if (cfg_addr_i == OFS_CLASS)
      cfg_rdata_o = {CLASS_CODE, 5'b0, native_q[1], 1'b1, native_q[0], REV_ID};
    else if (cfg_addr_i == OFS_MISC)
      cfg_rdata_o = {16'h0000, lat_q, 8'h00};
    else if (cfg_addr_i == OFS_INTR)
      cfg_rdata_o = any_native ? {16'h0000, 8'h01, line_q} : 32'h0;
    for (int ch = 0; ch < NCH; ch++) begin
      if (cfg_addr_i == OFS_BAR0 + CFG_IW'(2*ch))
        cfg_rdata_o = native_q[ch] ? cmd_q[ch] : 32'h0;
      if (cfg_addr_i == OFS_BAR0 + CFG_IW'(2*ch + 1))
        cfg_rdata_o = native_q[ch] ? ctl_q[ch] : 32'h0;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_out
    assign chan_o[ch].native = native_q[ch];
    assign chan_o[ch].cmd_hi = cmd_q[ch][31:3];
    assign chan_o[ch].ctl_hi = ctl_q[ch][31:2];
  end

  // R2
  progif_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr_i == OFS_CLASS) |-> (cfg_rdata_o[9] && cfg_rdata_o[15:11] == 5'b0));
  // R5
  mode_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_i && cfg_addr_i == OFS_CLASS && cfg_be_i[1]) |=>
      (native_q == {$past(cfg_wdata_i[10]), $past(cfg_wdata_i[8])}));
  // R4
  bar_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!native_q[0] && cfg_addr_i == OFS_BAR0) |-> (cfg_rdata_o == 32'h0));
  // R7
  intr_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_native && cfg_addr_i == OFS_INTR) |-> (cfg_rdata_o[15:8] == 8'h01));
endmodule

// File: rtl/ide_chan_match.sv
`timescale 1ns/1ps
module ide_chan_match #(
  parameter int          IO_AW   = 16,
  parameter logic [31:0] LEG_CMD = 32'h0000_01F0,
  parameter logic [31:0] LEG_CTL = 32'h0000_03F4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_valid_i,
  input  logic [IO_AW-1:0] io_addr_i,
  input  logic             enable_i,
  input  logic             native_i,
  input  logic [31:3]      cmd_hi_i,
  input  logic [31:2]      ctl_hi_i,
  output logic             cmd_hit_o,
  output logic             ctl_hit_o
);
  localparam logic [1:0] CTL_BYTE = 2'b10;

  logic [31:0] io32;
  logic [31:3] cmd_sel;
  logic [31:2] ctl_sel;
  logic        live;

  assign io32    = 32'(io_addr_i);
  assign live    = io_valid_i & enable_i;
  assign cmd_sel = native_i ? cmd_hi_i : LEG_CMD[31:3];
  assign ctl_sel = native_i ? ctl_hi_i : LEG_CTL[31:2];

  assign cmd_hit_o = live && (io32[31:3] == cmd_sel);
  assign ctl_hit_o = live && (io32[31:2] == ctl_sel) && (io32[1:0] == CTL_BYTE);

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_i || !io_valid_i) |-> (!cmd_hit_o && !ctl_hit_o));
  // R3
  legacy_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!native_i && ctl_hit_o) |-> (io32 == LEG_CTL + 32'd2));
endmodule

// File: rtl/ide_chan_decode.sv
`timescale 1ns/1ps
module ide_chan_decode
  import ide_dec_pkg::*;
#(
  parameter int          IO_AW      = 16,
  parameter logic [7:0]  REV_ID     = 8'h00,
  parameter logic [15:0] CLASS_CODE = 16'h0101
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_i,
  input  logic [5:0]       cfg_addr_i,
  input  logic [3:0]       cfg_be_i,
  input  logic [31:0]      cfg_wdata_i,
  output logic [31:0]      cfg_rdata_o,
  input  logic             io_valid_i,
  input  logic [IO_AW-1:0] io_addr_i,
  input  logic [1:0]       chan_en_i,
  output logic             pri_cmd_hit_o,
  output logic             pri_ctl_hit_o,
  output logic             sec_cmd_hit_o,
  output logic             sec_ctl_hit_o,
  input  logic [1:0]       chan_irq_i,
  output logic [1:0]       leg_irq_o,
  output logic             inta_o
);
  localparam int NHIT = 2 * NCH;

  logic                 rst_meta_q, rst_sync_q;
  chan_cfg_t [NCH-1:0]  chan_cfg;
  logic [NHIT-1:0]      raw_hit, grant;
  logic [NCH-1:0]       native;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  ide_cfg_regs #(.REV_ID(REV_ID), .CLASS_CODE(CLASS_CODE)) i_cfg (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .cfg_wr_i   (cfg_wr_i),
    .cfg_addr_i (cfg_addr_i),
    .cfg_be_i   (cfg_be_i),
    .cfg_wdata_i(cfg_wdata_i),
    .cfg_rdata_o(cfg_rdata_o),
    .chan_o     (chan_cfg)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    assign native[ch] = chan_cfg[ch].native;
    ide_chan_match #(
      .IO_AW  (IO_AW),
      .LEG_CMD(leg_cmd(ch)),
      .LEG_CTL(leg_ctl(ch))
    ) i_match (
      .clk       (clk),
      .rst_n     (rst_sync_q),
      .io_valid_i(io_valid_i),
      .io_addr_i (io_addr_i),
      .enable_i  (chan_en_i[ch]),
      .native_i  (chan_cfg[ch].native),
      .cmd_hi_i  (chan_cfg[ch].cmd_hi),
      .ctl_hi_i  (chan_cfg[ch].ctl_hi),
      .cmd_hit_o (raw_hit[2*ch]),
      .ctl_hit_o (raw_hit[2*ch+1])
    );
  end

  // lowest index wins on overlapping windows
  assign grant = raw_hit & (~raw_hit + NHIT'(1));

  assign pri_cmd_hit_o = grant[0];
  assign pri_ctl_hit_o = grant[1];
  assign sec_cmd_hit_o = grant[2];
  assign sec_ctl_hit_o = grant[3];

  assign leg_irq_o = chan_irq_i & ~native;
  assign inta_o    = |(chan_irq_i & native);

  // R10
  one_hit_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $onehot0({pri_cmd_hit_o, pri_ctl_hit_o, sec_cmd_hit_o, sec_ctl_hit_o}));
  // R10
  pri_first_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    raw_hit[0] |-> pri_cmd_hit_o);
  // R11
  irq_split_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    native[0] |-> !leg_irq_o[0]);
endmodule

// File: tb/test_ide_chan_decode.sv
`timescale 1ns/1ps
module test_ide_chan_decode;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [5:0]  cfg_addr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        io_valid;
  logic [15:0] io_addr;
  logic [1:0]  chan_en;
  logic        pch, pct, sch, sct;
  logic [1:0]  chan_irq;
  logic [1:0]  leg_irq;
  logic        inta;

  int n_chk = 0;
  int n_bad = 0;
  logic [1:0] m_nat;
  int         m_cmd [2];
  int         m_ctl [2];

  always #4 clk = ~clk;

  ide_chan_decode i_ide_chan_decode (
    .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr), .cfg_be_i(cfg_be),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .io_valid_i(io_valid), .io_addr_i(io_addr),
    .chan_en_i(chan_en), .pri_cmd_hit_o(pch), .pri_ctl_hit_o(pct), .sec_cmd_hit_o(sch),
    .sec_ctl_hit_o(sct), .chan_irq_i(chan_irq), .leg_irq_o(leg_irq), .inta_o(inta)
  );

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %08h expected %08h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(req, $sformatf("cfg read dword %0d", a), cfg_rdata, exp);
  endtask

  function automatic logic [3:0] exp_hit(input int a, input logic v, input logic [1:0] en);
    logic [3:0] raw;
    int cb, kb;
    raw = '0;
    for (int ch = 0; ch < 2; ch++) begin
      cb = m_nat[ch] ? (m_cmd[ch] & ~7) : ((ch == 0) ? 'h1F0 : 'h170);
      kb = m_nat[ch] ? (m_ctl[ch] & ~3) : ((ch == 0) ? 'h3F4 : 'h374);
      if (v && en[ch] && a >= cb && a < cb + 8) raw[2*ch] = 1'b1;
      if (v && en[ch] && a == kb + 2) raw[2*ch+1] = 1'b1;
    end
    for (int i = 0; i < 4; i++) if (raw[i]) return 4'(1 << i);
    return 4'b0;
  endfunction

  task automatic sweep(input string req, input logic [1:0] en, input logic v, input int top);
    chan_en = en;
    for (int a = 0; a < top; a++) begin
      @(negedge clk);
      io_valid = v; io_addr = 16'(a);
      #1;
      check(req, $sformatf("hits at %03h", a), {28'b0, sct, sch, pct, pch}, 32'(exp_hit(a, v, en)));
    end
    @(negedge clk);
    io_valid = 1'b0;
  endtask

  task automatic irq_chk(input logic [1:0] irq, input logic [1:0] exp_leg, input logic exp_a);
    @(negedge clk);
    chan_irq = irq;
    #1;
    check("R11", "irq routing", {29'b0, inta, leg_irq}, {29'b0, exp_a, exp_leg});
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_be = '0; cfg_wdata = '0;
    io_valid = 1'b0; io_addr = '0; chan_en = 2'b11; chan_irq = 2'b00;
    m_nat = 2'b00;
    m_cmd[0] = 'h1F1; m_ctl[0] = 'h3F5; m_cmd[1] = 'h171; m_ctl[1] = 'h375;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_chk("R1", 6'h02, 32'h0101_0200);
    rd_chk("R1", 6'h03, 32'h0);
    rd_chk("R1", 6'h04, 32'h0);
    rd_chk("R1", 6'h07, 32'h0);
    rd_chk("R1", 6'h0F, 32'h0);

    // R3 legacy decode, R9 enables and valid
    sweep("R3", 2'b11, 1'b1, 1024);
    sweep("R9", 2'b01, 1'b1, 1024);
    sweep("R9", 2'b10, 1'b1, 1024);
    sweep("R9", 2'b11, 1'b0, 64);

    // R4 compat mode drops base writes
    wr(6'h04, 4'hF, 32'h0000_0500);
    // R2 mode byte: ones everywhere gives 07h
    wr(6'h02, 4'hF, 32'hFFFF_FFFF);
    m_nat = 2'b11;
    rd_chk("R2", 6'h02, 32'h0101_0700);
    rd_chk("R4", 6'h04, 32'h0000_01F1);
    // R2 mode byte ignored without be[1]
    wr(6'h02, 4'b1101, 32'h0);
    rd_chk("R2", 6'h02, 32'h0101_0700);

    // R4 native bases with overlap
    wr(6'h04, 4'hF, 32'h0000_0307); m_cmd[0] = 'h301;
    wr(6'h05, 4'hF, 32'h0000_0307); m_ctl[0] = 'h305;
    wr(6'h06, 4'hF, 32'h0000_0300); m_cmd[1] = 'h301;
    wr(6'h07, 4'hF, 32'h0000_0328); m_ctl[1] = 'h329;
    rd_chk("R4", 6'h04, 32'h0000_0301);
    rd_chk("R4", 6'h05, 32'h0000_0305);
    rd_chk("R4", 6'h07, 32'h0000_0329);

    // R6 byte enables
    wr(6'h04, 4'b0010, 32'hFFFF_AAFF);
    rd_chk("R6", 6'h04, 32'h0000_AA01);
    wr(6'h04, 4'b1100, 32'h1234_0000);
    rd_chk("R6", 6'h04, 32'h1234_AA01);
    wr(6'h04, 4'hF, 32'h0000_0300);
    rd_chk("R6", 6'h04, 32'h0000_0301);

    sweep("R10", 2'b11, 1'b1, 1024);
    sweep("R4", 2'b10, 1'b1, 1024);

    // R8 latency and read-only fields
    wr(6'h03, 4'hF, 32'hFFFF_FFFF);
    rd_chk("R8", 6'h03, 32'h0000_FF00);
    sweep("R8", 2'b11, 1'b1, 1024);

    // R7 interrupt line and pin
    wr(6'h0F, 4'hF, 32'hFFFF_FF5A);
    rd_chk("R7", 6'h0F, 32'h0000_015A);

    // R5 timing: write to compat, request in the same cycle sees old mode
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 6'h02; cfg_be = 4'hF; cfg_wdata = 32'h0;
    io_valid = 1'b1; io_addr = 16'h01F0; chan_en = 2'b11;
    #1;
    check("R5", "old mode in write cycle", {31'b0, pch}, 32'h0);
    @(negedge clk);
    cfg_wr = 1'b0;
    #1;
    check("R5", "new mode next cycle", {31'b0, pch}, 32'h1);
    io_valid = 1'b0;
    m_nat = 2'b00;

    rd_chk("R7", 6'h0F, 32'h0);
    wr(6'h0F, 4'hF, 32'h0000_0077);
    wr(6'h02, 4'h2, 32'h0000_0400);
    m_nat = 2'b10;
    rd_chk("R7", 6'h0F, 32'h0000_015A);
    rd_chk("R4", 6'h04, 32'h0);
    sweep("R4", 2'b11, 1'b1, 1024);

    // R11 interrupt routing, secondary native
    irq_chk(2'b11, 2'b01, 1'b1);
    irq_chk(2'b01, 2'b01, 1'b0);
    irq_chk(2'b10, 2'b00, 1'b1);
    wr(6'h02, 4'h2, 32'h0000_0100);
    irq_chk(2'b11, 2'b10, 1'b1);
    irq_chk(2'b10, 2'b10, 1'b0);
    wr(6'h02, 4'h2, 32'h0000_0000);
    irq_chk(2'b11, 2'b11, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule